// File: doc/BRIEF.md
# Hi/Lo Multiply-Divide Unit

This block is the long-latency arithmetic unit of an integer core. It performs a 32x32 multiply or a 32/32 divide, in signed or unsigned form, over several cycles. It keeps the outcome in two private 32-bit result registers, HI and LO. A multiply leaves the 64-bit product split across the pair, with the upper half in HI. A divide leaves the quotient in LO and the remainder in HI.

An operation is launched with a one-cycle start pulse that carries an opcode and two operands. The unit then raises busy for a fixed number of cycles. The pipeline fetches results through a read port: it asks for HI or LO and takes the data when the port reports it valid. While an operation is in flight the read port withholds valid, which stalls the consumer.

Both datapaths are iterative, one bit per cycle. Multiply uses shift-and-add and divide uses restoring subtraction. Both work on operand magnitudes, and signs are applied on the last cycle.

Top module: `muldiv_unit`

## Requirements
- R1: With op_i = 2'b00 (signed multiply), HI:LO receives the 64-bit two's-complement product of a_i and b_i, with HI holding bits 63..32.
- R2: With op_i = 2'b01 (unsigned multiply), HI:LO receives the 64-bit unsigned product, with HI holding bits 63..32.
- R3: With op_i = 2'b10 (signed divide) and a nonzero divisor, LO receives the quotient rounded toward zero and HI receives a remainder that carries the dividend's sign.
- R4: With op_i = 2'b11 (unsigned divide) and a nonzero divisor, LO receives the unsigned quotient and HI receives the unsigned remainder.
- R5: A divide of either signedness with b_i = 0 finishes normally and sets LO to 32'hFFFF_FFFF and HI to a_i.
- R6: rd_valid_o is high exactly when rd_req_i is high and busy_o is low. rd_data_o shows HI when rd_sel_i = 1 and LO when rd_sel_i = 0. A read during busy is therefore held off.
- R7: A start while idle raises busy_o on the next cycle. busy_o stays high for exactly 32 cycles, and the new HI/LO values are readable in the first cycle after busy_o falls.
- R8: HI and LO keep their earlier contents until the operation completes. A start pulse that arrives while busy_o is high is ignored, so neither the timing nor the result of the operation in flight changes.
- R9: After reset, busy_o is low and HI and LO both read as zero.
- R10: The signed divide of 32'h8000_0000 by 32'hFFFF_FFFF yields LO = 32'h8000_0000 and HI = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch pulse, honoured only while idle |
| op_i | input | 2 | Operation: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| a_i | input | 32 | Multiplicand or dividend |
| b_i | input | 32 | Multiplier or divisor |
| rd_req_i | input | 1 | Request to read a result register |
| rd_sel_i | input | 1 | Read select: 1 = HI, 0 = LO |
| busy_o | output | 1 | Operation in progress |
| rd_valid_o | output | 1 | Read data valid (request and not busy) |
| rd_data_o | output | 32 | Selected result register |

## Verification
The assertions assume that reset is asserted before the first operation and that start_i, rd_req_i and the operands always hold known values. They place no limit on when start_i arrives, so a start issued during busy is legal input that the unit must drop. The bench drives every input on the falling clock edge and keeps them at defined values at all times. It deliberately pulses start and read requests in the middle of an operation, so that the drop and stall paths are exercised within those assumptions.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MULS = 2'b00,
    OP_MULU = 2'b01,
    OP_DIVS = 2'b10,
    OP_DIVU = 2'b11
  } mdu_op_e;
endpackage

// File: rtl/mdu_mul_core.sv
// Shift-and-add multiplier on unsigned magnitudes, one bit per step.
// prod_o shows the value the registers take at the coming edge.
module mdu_mul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_o
);
  logic [W-1:0] mcand_q, mcand_d;
  logic [W-1:0] upper_q, upper_d;
  logic [W-1:0] lower_q, lower_d;
  logic [W-1:0] addend;
  logic [W:0]   sum;

  always_comb begin
    addend  = lower_q[0] ? mcand_q : '0;
    sum     = {1'b0, upper_q} + {1'b0, addend};
    mcand_d = mcand_q;
    upper_d = upper_q;
    lower_d = lower_q;
    if (load_i) begin
      mcand_d = mcand_i;
      upper_d = '0;
      lower_d = mplier_i;
    end else if (step_i) begin
      upper_d = sum[W:1];
      lower_d = {sum[0], lower_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      upper_q <= '0;
      lower_q <= '0;
    end else if (load_i || step_i) begin
      mcand_q <= mcand_d;
      upper_q <= upper_d;
      lower_q <= lower_d;
    end
  end

  assign prod_o = {upper_d, lower_d};
endmodule

// File: rtl/mdu_div_core.sv
// Restoring divider on unsigned magnitudes, one quotient bit per step.
// quo_o and rem_o show the values the registers take at the coming edge.
module mdu_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] dvs_q, dvs_d;
  logic [W-1:0] rem_q, rem_d;
  logic [W-1:0] quo_q, quo_d;
  logic [W:0]   shifted;
  logic [W-1:0] trial;
  logic         fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    fits    = (shifted >= {1'b0, dvs_q});
    trial   = W'(shifted - {1'b0, dvs_q});
    dvs_d   = dvs_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    if (load_i) begin
      dvs_d = divisor_i;
      rem_d = '0;
      quo_d = dividend_i;
    end else if (step_i) begin
      rem_d = fits ? trial : shifted[W-1:0];
      quo_d = {quo_q[W-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvs_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
    end else if (load_i || step_i) begin
      dvs_q <= dvs_d;
      rem_q <= rem_d;
      quo_q <= quo_d;
    end
  end

  assign quo_o = quo_d;
  assign rem_o = rem_d;
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         rd_req_i,
  input  logic         rd_sel_i,
  output logic         busy_o,
  output logic         rd_valid_o,
  output logic [W-1:0] rd_data_o
);
  localparam int            CW   = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mdu_op_e       op;
  logic          sgn, a_neg, b_neg, b_zero;
  logic [W-1:0]  a_mag, b_mag;
  logic          accept, finish;

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          is_div_q, is_div_d;
  logic          neg_main_q, neg_main_d;
  logic          neg_rem_q, neg_rem_d;
  logic [W-1:0]  hi_q, hi_d, lo_q, lo_d;

  logic [2*W-1:0] prod_raw, prod_fix;
  logic [W-1:0]   quo_raw, rem_raw, quo_fix, rem_fix;

  // operand preparation
  always_comb begin
    op     = mdu_op_e'(op_i);
    sgn    = (op == OP_MULS) || (op == OP_DIVS);
    a_neg  = sgn & a_i[W-1];
    b_neg  = sgn & b_i[W-1];
    a_mag  = a_neg ? (~a_i + 1'b1) : a_i;
    b_mag  = b_neg ? (~b_i + 1'b1) : b_i;
    b_zero = ~|b_i;
    accept = start_i & ~busy_q;
    finish = busy_q & (cnt_q == LAST);
  end

  mdu_mul_core #(.W(W)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept),
    .step_i   (busy_q & ~is_div_q),
    .mcand_i  (a_mag),
    .mplier_i (b_mag),
    .prod_o   (prod_raw)
  );

  mdu_div_core #(.W(W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept),
    .step_i     (busy_q & is_div_q),
    .dividend_i (a_mag),
    .divisor_i  (b_mag),
    .quo_o      (quo_raw),
    .rem_o      (rem_raw)
  );

  // sign fix-up of the final step
  always_comb begin
    prod_fix = neg_main_q ? (~prod_raw + 1'b1) : prod_raw;
    quo_fix  = neg_main_q ? (~quo_raw + 1'b1) : quo_raw;
    rem_fix  = neg_rem_q ? (~rem_raw + 1'b1) : rem_raw;
  end

  // next state
  always_comb begin
    busy_d     = busy_q;
    cnt_d      = cnt_q;
    is_div_d   = is_div_q;
    neg_main_d = neg_main_q;
    neg_rem_d  = neg_rem_q;
    hi_d       = hi_q;
    lo_d       = lo_q;
    if (accept) begin
      busy_d   = 1'b1;
      cnt_d    = '0;
      is_div_d = op_i[1];
      if (op_i[1]) begin
        neg_main_d = (a_neg ^ b_neg) & ~b_zero;
        neg_rem_d  = a_neg;
      end else begin
        neg_main_d = a_neg ^ b_neg;
        neg_rem_d  = 1'b0;
      end
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (finish) begin
        busy_d = 1'b0;
        if (is_div_q) begin
          hi_d = rem_fix;
          lo_d = quo_fix;
        end else begin
          hi_d = prod_fix[2*W-1:W];
          lo_d = prod_fix[W-1:0];
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      is_div_q   <= 1'b0;
      neg_main_q <= 1'b0;
      neg_rem_q  <= 1'b0;
      hi_q       <= '0;
      lo_q       <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      if (accept) begin
        is_div_q   <= is_div_d;
        neg_main_q <= neg_main_d;
        neg_rem_q  <= neg_rem_d;
      end
      if (finish) begin
        hi_q <= hi_d;
        lo_q <= lo_d;
      end
    end
  end

  assign busy_o     = busy_q;
  assign rd_valid_o = rd_req_i & ~busy_q;
  assign rd_data_o  = rd_sel_i ? hi_q : lo_q;
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         busy_o,
  input logic         rd_req_i,
  input logic         rd_valid_o,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  localparam int CW = $clog2(W) + 1;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
    else             run_cnt <= '0;
  end

  a_r6_read_stall: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !rd_valid_o);

  a_r6_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && !busy_o) |-> rd_valid_o);

  a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_cnt == CW'(W)));

  a_r8_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ($stable(hi_q) && $stable(lo_q)));

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && run_cnt < CW'(W - 1)) |=> busy_o);
endmodule

bind muldiv_unit mdu_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .rd_req_i   (rd_req_i),
  .rd_valid_o (rd_valid_o),
  .hi_q       (hi_q),
  .lo_q       (lo_q)
);

// File: tb/muldiv_unit_tb.sv
`timescale 1ns/1ps
module muldiv_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  op_i;
  logic [31:0] a_i, b_i;
  logic        rd_req_i, rd_sel_i;
  logic        busy_o, rd_valid_o;
  logic [31:0] rd_data_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  muldiv_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .rd_req_i(rd_req_i), .rd_sel_i(rd_sel_i),
    .busy_o(busy_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    if (op[1] && b == 0) return "R5";
    if (op == 2'b10 && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R10";
    case (op)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] hi, output logic [31:0] lo);
    longint      sp, sq, sr;
    logic [63:0] up;
    case (op)
      2'b00: begin
        sp = longint'($signed(a)) * longint'($signed(b));
        hi = sp[63:32]; lo = sp[31:0];
      end
      2'b01: begin
        up = {32'b0, a} * {32'b0, b};
        hi = up[63:32]; lo = up[31:0];
      end
      2'b10: begin
        if (b == 0) begin hi = a; lo = 32'hFFFF_FFFF; end
        else begin
          sq = longint'($signed(a)) / longint'($signed(b));
          sr = longint'($signed(a)) % longint'($signed(b));
          hi = sr[31:0]; lo = sq[31:0];
        end
      end
      default: begin
        if (b == 0) begin hi = a; lo = 32'hFFFF_FFFF; end
        else begin hi = a % b; lo = a / b; end
      end
    endcase
  endtask

  task automatic read_both(input string req, input logic [31:0] ehi, input logic [31:0] elo);
    rd_req_i = 1'b1; rd_sel_i = 1'b1; #1;
    check("R6 valid when idle", {31'b0, rd_valid_o}, 32'd1);
    check({req, " HI"}, rd_data_o, ehi);
    rd_sel_i = 1'b0; #1;
    check({req, " LO"}, rd_data_o, elo);
    rd_req_i = 1'b0;
  endtask

  // poke: drive a second start mid-flight (R8) and a stalled read (R6)
  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b, input bit poke);
    logic [31:0] ehi, elo;
    int cycles;
    model(op, a, b, ehi, elo);
    @(negedge clk);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk);
    start_i = 1'b0;
    check("R7 busy after start", {31'b0, busy_o}, 32'd1);
    cycles = 0;
    while (busy_o && cycles < 100) begin
      cycles++;
      if (poke && cycles == 3) begin
        rd_req_i = 1'b1; rd_sel_i = 1'b1; #1;
        check("R6 read stalled while busy", {31'b0, rd_valid_o}, 32'd0);
        rd_req_i = 1'b0;
      end
      if (poke && cycles == 5) begin
        start_i = 1'b1; op_i = ~op; a_i = ~a; b_i = b + 32'd3;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    check(poke ? "R8 busy length with ignored start" : "R7 busy length",
          cycles, 32'd32);
    read_both(poke ? "R8 result of first op" : tag_of(op, a, b), ehi, elo);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] ra, rb;
    logic [1:0]  rop;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; op_i = 2'b00; a_i = '0; b_i = '0;
    rd_req_i = 1'b0; rd_sel_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 busy after reset", {31'b0, busy_o}, 32'd0);
    read_both("R9 reset", 32'd0, 32'd0);

    // directed corners
    run_op(2'b00, 32'hFFFF_FFFD, 32'd7, 1'b0);          // R1 negative x positive
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 1'b0);  // R1 most negative squared
    run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);  // R1 -1 x -1
    run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);  // R2 max unsigned
    run_op(2'b10, 32'hFFFF_FFF9, 32'd2, 1'b0);          // R3 -7/2
    run_op(2'b10, 32'd7, 32'hFFFF_FFFE, 1'b0);          // R3 7/-2
    run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);  // R10
    run_op(2'b11, 32'hFFFF_FFFF, 32'd16, 1'b0);         // R4
    run_op(2'b10, 32'hFFFF_FFFB, 32'd0, 1'b0);          // R5 signed
    run_op(2'b11, 32'h1234_5678, 32'd0, 1'b0);          // R5 unsigned
    run_op(2'b00, 32'd12345, 32'hFFFF_0000, 1'b1);      // R8 start ignored
    run_op(2'b10, 32'hF000_0001, 32'd977, 1'b1);        // R8 during divide

    // constrained random
    for (int i = 0; i < 160; i++) begin
      rop = 2'($urandom);
      ra  = $urandom;
      case ($urandom % 4)
        0: rb = $urandom % 16;
        1: rb = 32'hFFFF_FFF0 | ($urandom % 16);
        default: rb = $urandom;
      endcase
      run_op(rop, ra, rb, (i % 17) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule